// File: doc/BRIEF.md
# Rotate-XOR Diffusion Layer

This unit is the linear mixing stage of a block cipher round. A block of `NUM_WORDS` words, each `WORD_W` bits wide, is loaded. The unit then rewrites the words one at a time. Each update XORs together left-rotated copies of every word, using a fixed table of rotation amounts, and writes the sum back into the target word. Updates happen in place, so a later update sees the words that earlier updates already changed. The same hardware runs the exact inverse, which undoes a forward run step by step in reverse order. A run covers either one or two passes over the words.

The handshake is small. While the unit is idle, `startReady` is high. The caller presents a block, a direction and a pass count together with `startValid`. The unit performs one word update per clock and pulses `done` for one cycle when the run has finished. The result stays on `blockOut` until the next run is accepted. The default build uses four 32-bit words with rotations {0, 1, 7, 14}. A 256-bit build with four 64-bit words and rotations {0, 8, 9, 11} is selected through the parameters alone.

Top module: `rotxor_diffuser`

## Requirements
- R1: Word k of the block occupies bits [k*WORD_W +: WORD_W] of `blockIn` and `blockOut`, so word 0 sits in the least significant bits.
- R2: Forward step j replaces word j with the XOR, for i = 0..NUM_WORDS-1, of word ((i + j) mod NUM_WORDS) rotated left by ROT_AMT[i]. The steps run in the order j = 0, 1, …, NUM_WORDS-1, and each step reads the words left by the steps before it.
- R3: A left rotation by d moves bit b of a word to bit (b + d) mod WORD_W. With the default constants, a single set bit at bit 0 of word 3 gives, after one forward pass, the output block 128'h01004009_00000402_10000080_00004000.
- R4: When `twoPass` is 1 at acceptance, the run performs 2*NUM_WORDS steps (two full passes). When it is 0, the run performs NUM_WORDS steps.
- R5: When `inverseMode` is 1 at acceptance, the steps run in reverse order. Inverse step j XORs word j with word ((i + j) mod NUM_WORDS) rotated by ROT_AMT[i] for every i ≥ 1, then rotates the sum right by ROT_AMT[0]. Feeding a forward result into an inverse run with the same pass count returns the original block.
- R6: The unit performs one step per clock. `done` is high for exactly one cycle, N clock edges after the accepting edge, where N is the step count of the run.
- R7: `startReady` is low while a run is in progress, and `startValid` is ignored during that time.
- R8: A step changes only its target word. Outside a run, `blockOut` holds its value.
- R9: An all-zero block gives an all-zero result in every mode.
- R10: After reset, `startReady` is 1, `done` is 0 and `blockOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Request to start a run with the presented block |
| startReady | output | 1 | High while idle; a run is accepted when both are high |
| blockIn | input | WORD_W*NUM_WORDS | Block to transform |
| inverseMode | input | 1 | 0 = forward, 1 = inverse |
| twoPass | input | 1 | 0 = one pass, 1 = two passes |
| done | output | 1 | One-cycle pulse when a run finishes |
| blockOut | output | WORD_W*NUM_WORDS | Working block and final result |

## Verification
The zero block separates a correct XOR network from one that leaks constants. Single set bits, placed in each source word, expose the rotation direction, the amount used per word and the in-place ordering, because a wrong order or a stale read moves or cancels specific output bits. Random blocks run forward and then inverse, in both pass counts, and must come back unchanged, which catches any mismatch between the two directions. A start request raised in the middle of a run checks that the running computation and its single `done` pulse are undisturbed.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rxdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic stepEn;
    logic inverse;
  } rxdStrobe_t;

endpackage

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int NUM_WORDS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       inverseMode,
  input  logic       twoPass,
  output logic       startReady,
  output logic       done,
  output rxdStrobe_t strobe,
  output logic [$clog2(NUM_WORDS)-1:0] stepIdx
);

  localparam int IW    = $clog2(NUM_WORDS);
  localparam int LENW  = $clog2(2 * NUM_WORDS + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WORDS - 1);

  rxdState_e state;
  logic [IW-1:0] wordCnt;
  logic          passSecond;
  logic          twoPassQ;
  logic          inverseQ;
  logic          lastStep;
  logic          accept;

  assign accept     = (state == ST_IDLE) && startValid;
  assign lastStep   = (wordCnt == LAST_IDX) && (!twoPassQ || passSecond);
  assign startReady = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      wordCnt    <= '0;
      passSecond <= 1'b0;
      twoPassQ   <= 1'b0;
      inverseQ   <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state      <= ST_RUN;
        wordCnt    <= '0;
        passSecond <= 1'b0;
        twoPassQ   <= twoPass;
        inverseQ   <= inverseMode;
      end else if (state == ST_RUN) begin
        if (lastStep) begin
          state   <= ST_IDLE;
          wordCnt <= '0;
          done    <= 1'b1;
        end else if (wordCnt == LAST_IDX) begin
          wordCnt    <= '0;
          passSecond <= 1'b1;
        end else begin
          wordCnt <= wordCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.load    = accept;
    strobe.stepEn  = (state == ST_RUN);
    strobe.inverse = inverseQ;
    stepIdx        = inverseQ ? (LAST_IDX - wordCnt) : wordCnt;
  end

  // run-length tracker for the step-count property
  logic [LENW-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               runLen <= '0;
    else if (accept)         runLen <= '0;
    else if (state == ST_RUN) runLen <= runLen + 1'b1;
  end

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_done_follows_run: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(state == ST_RUN));

  a_r4_run_length: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runLen == (twoPassQ ? LENW'(2 * NUM_WORDS) : LENW'(NUM_WORDS))));

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !lastStep) |=> (!startReady && !strobe.load));

endmodule

// File: rtl/rxd_datapath.sv
module rxd_datapath
  import rxd_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          NUM_WORDS = 4,
  parameter int unsigned ROT_AMT [NUM_WORDS] = '{0, 1, 7, 14}
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rxdStrobe_t                  strobe,
  input  logic [$clog2(NUM_WORDS)-1:0] stepIdx,
  input  logic [WORD_W*NUM_WORDS-1:0] blockIn,
  output logic [WORD_W*NUM_WORDS-1:0] blockOut
);

  localparam int IW = $clog2(NUM_WORDS);

  function automatic logic [WORD_W-1:0] rotLeft(input logic [WORD_W-1:0] x,
                                                input int unsigned amt);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << (amt % WORD_W);
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] rotRight(input logic [WORD_W-1:0] x,
                                                 input int unsigned amt);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} >> (amt % WORD_W);
    return dbl[WORD_W-1:0];
  endfunction

  logic [WORD_W-1:0] wordQ  [NUM_WORDS];
  logic [WORD_W-1:0] fwdVal [NUM_WORDS];
  logic [WORD_W-1:0] invVal [NUM_WORDS];
  logic [WORD_W-1:0] nextWord;

  // candidate results of every step, forward and inverse
  always_comb begin
    for (int j = 0; j < NUM_WORDS; j++) begin
      logic [WORD_W-1:0] fAcc;
      logic [WORD_W-1:0] iAcc;
      fAcc = rotLeft(wordQ[j], ROT_AMT[0]);
      iAcc = wordQ[j];
      for (int i = 1; i < NUM_WORDS; i++) begin
        fAcc = fAcc ^ rotLeft(wordQ[(i + j) % NUM_WORDS], ROT_AMT[i]);
        iAcc = iAcc ^ rotLeft(wordQ[(i + j) % NUM_WORDS], ROT_AMT[i]);
      end
      fwdVal[j] = fAcc;
      invVal[j] = rotRight(iAcc, ROT_AMT[0]);
    end
  end

  assign nextWord = strobe.inverse ? invVal[stepIdx] : fwdVal[stepIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_WORDS; k++) wordQ[k] <= '0;
    end else if (strobe.load) begin
      for (int k = 0; k < NUM_WORDS; k++) wordQ[k] <= blockIn[k*WORD_W +: WORD_W];
    end else if (strobe.stepEn) begin
      wordQ[stepIdx] <= nextWord;
    end
  end

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    assign blockOut[k*WORD_W +: WORD_W] = wordQ[k];

    a_r8_other_word_kept: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.stepEn && !strobe.load && stepIdx != IW'(k)) |=> $stable(wordQ[k]));
  end

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.stepEn) |=> $stable(blockOut));

  a_r7_no_load_mid_run: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.stepEn));

endmodule

// File: rtl/rotxor_diffuser.sv
module rotxor_diffuser
  import rxd_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          NUM_WORDS = 4,
  parameter int unsigned ROT_AMT [NUM_WORDS] = '{0, 1, 7, 14},
  localparam int         BLOCK_W   = WORD_W * NUM_WORDS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  output logic               startReady,
  input  logic [BLOCK_W-1:0] blockIn,
  input  logic               inverseMode,
  input  logic               twoPass,
  output logic               done,
  output logic [BLOCK_W-1:0] blockOut
);

  rxdStrobe_t                   strobe;
  logic [$clog2(NUM_WORDS)-1:0] stepIdx;

  rxd_ctrl #(
    .NUM_WORDS(NUM_WORDS)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .inverseMode(inverseMode),
    .twoPass    (twoPass),
    .startReady (startReady),
    .done       (done),
    .strobe     (strobe),
    .stepIdx    (stepIdx)
  );

  rxd_datapath #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS),
    .ROT_AMT  (ROT_AMT)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .stepIdx (stepIdx),
    .blockIn (blockIn),
    .blockOut(blockOut)
  );

  a_r10_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (startReady && !done));

endmodule

// File: tb/rotxor_diffuser_tb_top.sv
`timescale 1ns/1ps
module rotxor_diffuser_tb_top;

  localparam int W  = 32;
  localparam int U  = 4;
  localparam int BW = W * U;
  localparam int unsigned ROT [U] = '{0, 1, 7, 14};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startValid = 1'b0;
  logic          startReady;
  logic [BW-1:0] blockIn = '0;
  logic          inverseMode = 1'b0;
  logic          twoPass = 1'b0;
  logic          done;
  logic [BW-1:0] blockOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rotxor_diffuser #(.WORD_W(W), .NUM_WORDS(U), .ROT_AMT(ROT)) dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .blockIn(blockIn), .inverseMode(inverseMode), .twoPass(twoPass),
    .done(done), .blockOut(blockOut)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference, bit by bit
  function automatic logic [W-1:0] mRotL(input logic [W-1:0] x, input int d);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) r[(b + d) % W] = x[b];
    return r;
  endfunction

  function automatic logic [W-1:0] mRotR(input logic [W-1:0] x, input int d);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) r[b] = x[(b + d) % W];
    return r;
  endfunction

  logic [W-1:0] mw [U];
  bit mBusy, mDone, mInv;
  int mCnt, mTotal;

  function automatic logic [BW-1:0] mBlock();
    logic [BW-1:0] v;
    for (int k = 0; k < U; k++) v[k*W +: W] = mw[k];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < U; k++) mw[k] = '0;
      mBusy = 0; mDone = 0; mCnt = 0; mTotal = 0; mInv = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        int j;
        logic [W-1:0] acc;
        j = mInv ? (U - 1 - (mCnt % U)) : (mCnt % U);
        if (!mInv) begin
          acc = '0;
          for (int i = 0; i < U; i++) acc ^= mRotL(mw[(i + j) % U], ROT[i]);
          mw[j] = acc;
        end else begin
          acc = mw[j];
          for (int i = 1; i < U; i++) acc ^= mRotL(mw[(i + j) % U], ROT[i]);
          mw[j] = mRotR(acc, ROT[0]);
        end
        mCnt++;
        if (mCnt == mTotal) begin
          mBusy = 0;
          mDone = 1;
        end
      end else if (startValid) begin
        for (int k = 0; k < U; k++) mw[k] = blockIn[k*W +: W];
        mBusy = 1; mCnt = 0; mInv = inverseMode;
        mTotal = twoPass ? 2 * U : U;
      end
    end
  end

  // per-cycle comparison against the model (R2, R5, R6, R7, R8)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(blockOut == mBlock(), "R2 blockOut vs model", blockOut, mBlock());
      chk(done == mDone, "R6 done vs model", BW'(done), BW'(mDone));
      chk(startReady == !mBusy, "R7 startReady vs model", BW'(startReady), BW'(!mBusy));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic runOne(input logic [BW-1:0] blk, input bit inv, input bit two,
                        input bit injectBusy,
                        output logic [BW-1:0] res, output int lat);
    @(negedge clk);
    blockIn = blk; inverseMode = inv; twoPass = two; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    lat = 0;
    while (!done) begin
      if (injectBusy && lat == 2) begin
        blockIn = ~blk; inverseMode = ~inv; twoPass = ~two; startValid = 1'b1;
      end else begin
        startValid = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    startValid = 1'b0;
    res = blockOut;
  endtask

  initial begin
    logic [BW-1:0] res, back, orig, held;
    int lat;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(startReady == 1'b1, "R10 startReady after reset", BW'(startReady), BW'(1));
    chk(done == 1'b0, "R10 done after reset", BW'(done), BW'(0));
    chk(blockOut == '0, "R10 blockOut after reset", blockOut, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R9 zero block in every mode
    for (int m = 0; m < 4; m++) begin
      runOne('0, m[0], m[1], 0, res, lat);
      chk(res == '0, "R9 zero in zero out", res, '0);
    end

    // R3, R1: known single-bit pattern
    runOne(BW'(1) << (3 * W), 0, 0, 0, res, lat);
    chk(res == 128'h01004009_00000402_10000080_00004000, "R3 single bit word3",
        res, 128'h01004009_00000402_10000080_00004000);
    chk(lat == U, "R6 one-pass latency", BW'(lat), BW'(U));

    // single bits in each source word, forward, then inverted back (R1, R2, R5)
    for (int k = 0; k < U; k++) begin
      orig = BW'(1) << (k * W + 5);
      runOne(orig, 0, 0, 0, res, lat);
      chk(res != orig && res != '0, "R2 single bit spreads", res, orig);
      runOne(res, 1, 0, 0, back, lat);
      chk(back == orig, "R5 single bit round trip", back, orig);
    end

    // random round trips, both pass counts (R4, R5, R6)
    for (int t = 0; t < 12; t++) begin
      bit two;
      two = t[0];
      orig = {$urandom, $urandom, $urandom, $urandom};
      runOne(orig, 0, two, 0, res, lat);
      chk(lat == (two ? 2 * U : U), "R4 step count", BW'(lat), BW'(two ? 2 * U : U));
      runOne(res, 1, two, 0, back, lat);
      chk(back == orig, "R5 random round trip", back, orig);
    end

    // R7: start requested mid-run is ignored
    orig = {$urandom, $urandom, $urandom, $urandom};
    runOne(orig, 0, 1, 1, res, lat);
    chk(lat == 2 * U, "R7 run length with busy start", BW'(lat), BW'(2 * U));
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", BW'(done), BW'(0));
    runOne(res, 1, 1, 0, back, lat);
    chk(back == orig, "R7 busy start left data intact", back, orig);

    // R8: output holds while idle
    held = blockOut;
    repeat (5) @(negedge clk);
    chk(blockOut == held, "R8 hold when idle", blockOut, held);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule